// File: doc/BRIEF.md
# Single-Clock FIFO With Threshold Flags

A first-in first-out buffer where reads and writes share one clock. A producer raises a write strobe with a data word, and a consumer raises a read strobe. Every cycle the block reports full, empty, the number of stored words, and two threshold flags. The threshold flags let a producer slow down early, and let a consumer wait until enough words have built up.

Parameters fix the word width, the depth and both threshold levels. A read-mode parameter chooses how the read strobe behaves. In normal mode the strobe is a command, and the requested word appears on the output after the clock edge. In show-ahead mode the oldest word already sits on the output, and the strobe only acknowledges it and removes it. Normal mode can add an output register that gives one more cycle of latency.

Overflow and underflow guards can each be turned off by a parameter. A synchronous flush input empties the buffer at the next edge, and an asynchronous clear input empties it at once.

Top module: `sfifo_top`

## Requirements
- R1: Accepted words leave in the order they were written, and each accepted write raises `count` by one at the next edge while each accepted read lowers it by one.
- R2: After clear, `count` is 0 and `empty` is 1. `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` equals DEPTH.
- R3: With the overflow guard on, a write while `full` is ignored, even if a read happens in the same cycle. `count` stays the same and the stored words are unchanged.
- R4: With the underflow guard on, a read while `empty` is ignored. A normal-mode `rd_data` keeps its value. A write in the same cycle is still accepted.
- R5: `almost_full` is 1 exactly when `count` >= AF_LEVEL.
- R6: `almost_empty` is 1 exactly when `count` < AE_LEVEL.
- R7: A write and a read together, while neither `full` nor `empty` is set, leave `count` unchanged.
- R8: In normal mode (MODE = RD_NORMAL, encoding 0), a read accepted at an edge puts the popped word on `rd_data` just after that edge. The word then holds until the next accepted read. With OUT_REG = 1 the word appears one edge later.
- R9: In show-ahead mode (MODE = RD_SHOWAHEAD, encoding 1), whenever `empty` is 0 `rd_data` shows the oldest stored word. A read moves the output to the next word.
- R10: `sclr` high at an edge empties the buffer and ignores any write or read in that cycle. A normal-mode `rd_data` is left untouched.
- R11: `aclr` high sets `count` to 0 and `empty` to 1 with no clock edge, and clears a normal-mode `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for reads and writes |
| aclr | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous flush, active high |
| wr_req | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to store |
| rd_req | input | 1 | Read command (normal) or acknowledge (show-ahead) |
| rd_data | output | WIDTH | Read word |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| count | output | log2(DEPTH)+1 | Number of stored words |
| almost_full | output | 1 | count >= AF_LEVEL |
| almost_empty | output | 1 | count < AE_LEVEL |

## Verification
The hardest case to reach from the ports is a simultaneous write and read at each exact fill level, especially at the two ends. At the full end the write must be refused. At the empty end the read must be refused. The stimulus reaches each level by flushing and then writing that many words, and only then presses both strobes. After that, a long pseudo-random run mixes writes, reads and occasional flushes. Normal, registered-normal and show-ahead copies are driven together and compared against a queue model.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   typedef enum logic {
      RD_NORMAL    = 1'b0,
      RD_SHOWAHEAD = 1'b1
   } rd_mode_e;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
   parameter int DEPTH     = 16,
   parameter int AF_LEVEL  = 12,
   parameter int AE_LEVEL  = 4,
   parameter bit OVF_GUARD = 1'b1,
   parameter bit UNF_GUARD = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          aclr,
   input  logic          sclr,
   input  logic          wr_req,
   input  logic          rd_req,
   output logic          wr_en,
   output logic          rd_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          almost_full,
   output logic          almost_empty
);
   logic [AW-1:0] wptr_q, rptr_q;
   logic [CW-1:0] cnt_q;

   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);

   assign wr_en = wr_req & ~sclr & (~full  | ~OVF_GUARD);
   assign rd_en = rd_req & ~sclr & (~empty | ~UNF_GUARD);

   always_ff @(posedge clk or posedge aclr) begin
      if (aclr) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else if (sclr) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) wptr_q <= wptr_q + 1'b1;
         if (rd_en) rptr_q <= rptr_q + 1'b1;
         cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
      end
   end

   assign wr_addr      = wptr_q;
   assign rd_addr      = rptr_q;
   assign count        = cnt_q;
   assign almost_full  = (cnt_q >= CW'(AF_LEVEL));
   assign almost_empty = (cnt_q <  CW'(AE_LEVEL));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (aclr)
      (OVF_GUARD && full && wr_req && !rd_req && !sclr) |=> (full && $stable(count)));

   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (aclr)
      (UNF_GUARD && empty && rd_req && !wr_req && !sclr) |=> (empty && $stable(count)));

   assert_rw_hold_R7: assert property (@(posedge clk) disable iff (aclr)
      (wr_req && rd_req && !sclr && !full && !empty) |=> $stable(count));

   assert_flush_R10: assert property (@(posedge clk) disable iff (aclr)
      sclr |=> (empty && !full));

   assert_count_step_R1: assert property (@(posedge clk) disable iff (aclr)
      (!sclr && wr_req && !rd_req && !full) |=> (count == $past(count) + 1'b1));

   assert_count_range_R2: assert property (@(posedge clk) disable iff (aclr)
      (OVF_GUARD && UNF_GUARD) |-> (count <= CW'(DEPTH)));
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int                  WIDTH   = 8,
   parameter int                  DEPTH   = 16,
   parameter sfifo_pkg::rd_mode_e MODE    = sfifo_pkg::RD_NORMAL,
   parameter bit                  OUT_REG = 1'b0,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             aclr,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   if (MODE == sfifo_pkg::RD_SHOWAHEAD) begin : g_ahead
      assign rd_data = mem[rd_addr];
   end else begin : g_normal
      logic [WIDTH-1:0] pop_q;
      always_ff @(posedge clk or posedge aclr) begin
         if (aclr)       pop_q <= '0;
         else if (rd_en) pop_q <= mem[rd_addr];
      end
      if (OUT_REG) begin : g_oreg
         logic [WIDTH-1:0] out_q;
         always_ff @(posedge clk or posedge aclr) begin
            if (aclr) out_q <= '0;
            else      out_q <= pop_q;
         end
         assign rd_data = out_q;
      end else begin : g_direct
         assign rd_data = pop_q;
      end

      assert_hold_R8: assert property (@(posedge clk) disable iff (aclr)
         !rd_en |=> $stable(pop_q));
   end
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top #(
   parameter int                  WIDTH     = 8,
   parameter int                  DEPTH     = 16,
   parameter int                  AF_LEVEL  = 12,
   parameter int                  AE_LEVEL  = 4,
   parameter sfifo_pkg::rd_mode_e MODE      = sfifo_pkg::RD_NORMAL,
   parameter bit                  OUT_REG   = 1'b0,
   parameter bit                  OVF_GUARD = 1'b1,
   parameter bit                  UNF_GUARD = 1'b1
) (
   input  logic                     clk,
   input  logic                     aclr,
   input  logic                     sclr,
   input  logic                     wr_req,
   input  logic [WIDTH-1:0]         wr_data,
   input  logic                     rd_req,
   output logic [WIDTH-1:0]         rd_data,
   output logic                     full,
   output logic                     empty,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     almost_full,
   output logic                     almost_empty
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 4 || DEPTH > 131072 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sfifo_top: DEPTH must be a power of two from 4 to 131072");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sfifo_top: WIDTH must be positive");
   end
   if (AF_LEVEL < 1 || AF_LEVEL > DEPTH || AE_LEVEL < 1 || AE_LEVEL > DEPTH) begin : g_bad_lvl
      $error("sfifo_top: threshold levels must lie in 1..DEPTH");
   end
   if (MODE == sfifo_pkg::RD_SHOWAHEAD && OUT_REG) begin : g_bad_mode
      $error("sfifo_top: OUT_REG applies to normal read mode only");
   end

   logic          wr_en, rd_en;
   logic [AW-1:0] wr_addr, rd_addr;

   sfifo_ctrl #(
      .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL),
      .OVF_GUARD(OVF_GUARD), .UNF_GUARD(UNF_GUARD)
   ) u_ctrl (
      .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .rd_req(rd_req),
      .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
      .count(count), .full(full), .empty(empty),
      .almost_full(almost_full), .almost_empty(almost_empty)
   );

   sfifo_store #(
      .WIDTH(WIDTH), .DEPTH(DEPTH), .MODE(MODE), .OUT_REG(OUT_REG)
   ) u_store (
      .clk(clk), .aclr(aclr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assert_flag_excl_R2: assert property (@(posedge clk) disable iff (aclr)
      !(full && empty));
endmodule

// File: tb/sim_sfifo_top.sv
module sim_sfifo_top;
   localparam int CLK_P = 10;
   localparam int W  = 8;
   localparam int D  = 8;
   localparam int AF = 6;
   localparam int AE = 2;

   logic clk = 1'b0;
   logic aclr = 1'b1, sclr = 1'b0, wr_req = 1'b0, rd_req = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd0, rd1, rd2;
   logic full0, empty0, af0, ae0, full1, empty1, af1, ae1, full2, empty2, af2, ae2;
   logic [3:0] cnt0, cnt1, cnt2;

   always #(CLK_P/2) clk = ~clk;

   sfifo_top #(.WIDTH(W), .DEPTH(D), .AF_LEVEL(AF), .AE_LEVEL(AE),
      .MODE(sfifo_pkg::RD_NORMAL), .OUT_REG(1'b0)) u0 (
      .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .wr_data(wr_data),
      .rd_req(rd_req), .rd_data(rd0), .full(full0), .empty(empty0), .count(cnt0),
      .almost_full(af0), .almost_empty(ae0));

   sfifo_top #(.WIDTH(W), .DEPTH(D), .AF_LEVEL(AF), .AE_LEVEL(AE),
      .MODE(sfifo_pkg::RD_SHOWAHEAD), .OUT_REG(1'b0)) u1 (
      .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .wr_data(wr_data),
      .rd_req(rd_req), .rd_data(rd1), .full(full1), .empty(empty1), .count(cnt1),
      .almost_full(af1), .almost_empty(ae1));

   sfifo_top #(.WIDTH(W), .DEPTH(D), .AF_LEVEL(AF), .AE_LEVEL(AE),
      .MODE(sfifo_pkg::RD_NORMAL), .OUT_REG(1'b1)) u2 (
      .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .wr_data(wr_data),
      .rd_req(rd_req), .rd_data(rd2), .full(full2), .empty(empty2), .count(cnt2),
      .almost_full(af2), .almost_empty(ae2));

   int checks = 0, fails = 0;
   int q[$];
   logic [W-1:0] exp0 = '0, exp2 = '0, dseed = '0;

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic chk_all();
      int n = q.size();
      chk("R1 count u0", int'(cnt0), n);
      chk("R1 count u1", int'(cnt1), n);
      chk("R1 count u2", int'(cnt2), n);
      chk("R2 empty", int'(empty0) + 2*int'(empty1) + 4*int'(empty2), (n == 0) ? 7 : 0);
      chk("R2 full",  int'(full0)  + 2*int'(full1)  + 4*int'(full2),  (n == D) ? 7 : 0);
      chk("R5 almost_full",  int'(af0) + 2*int'(af1) + 4*int'(af2), (n >= AF) ? 7 : 0);
      chk("R6 almost_empty", int'(ae0) + 2*int'(ae1) + 4*int'(ae2), (n <  AE) ? 7 : 0);
      chk("R8 normal rd_data", int'(rd0), int'(exp0));
      chk("R8 registered rd_data", int'(rd2), int'(exp2));
      if (n > 0) chk("R9 show-ahead head", int'(rd1), q[0]);
   endtask

   task automatic cyc(input bit w, input bit r, input bit s);
      logic [W-1:0] prev;
      int n;
      wr_req = w; rd_req = r; sclr = s; wr_data = dseed;
      @(posedge clk);
      prev = exp0;
      n = q.size();
      if (s) q.delete();
      else begin
         if (r && n > 0) exp0 = W'(q.pop_front());
         if (w && n < D) q.push_back(int'(dseed));
      end
      exp2 = prev;
      if (w) dseed = dseed + 8'd37;
      @(negedge clk);
      wr_req = 1'b0; rd_req = 1'b0; sclr = 1'b0;
      chk_all();
   endtask

   bit done = 1'b0;
   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      repeat (2) @(negedge clk);
      // R2 reset state
      chk("R2 reset count", int'(cnt0), 0);
      chk("R2 reset empty", int'(empty0 & empty1 & empty2), 1);
      aclr = 1'b0;
      @(negedge clk);
      chk_all();

      // R1 fill, then R3 overflow attempts with and without a read
      for (int i = 0; i < D; i++) cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R3 write while full ignored", int'(cnt0), D);
      cyc(1'b1, 1'b1, 1'b0);
      chk("R3 write+read while full", int'(cnt0), D - 1);

      // R1 drain in order, then R4 underflow
      for (int i = 0; i < D; i++) cyc(1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, 1'b0);
      chk("R4 read while empty ignored", int'(cnt0), 0);
      chk("R4 rd_data held", int'(rd0), int'(exp0));
      cyc(1'b1, 1'b1, 1'b0);
      chk("R4 write accepted with read on empty", int'(cnt0), 1);

      // R7 both strobes at every fill level
      for (int lvl = 0; lvl <= D; lvl++) begin
         cyc(1'b0, 1'b0, 1'b1);
         for (int k = 0; k < lvl; k++) cyc(1'b1, 1'b0, 1'b0);
         cyc(1'b1, 1'b1, 1'b0);
         if (lvl > 0 && lvl < D) chk("R7 count unchanged", int'(cnt0), lvl);
      end

      // R10 flush wins over write and read
      for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b1, 1'b1, 1'b1);
      chk("R10 flush empties", int'(empty0), 1);

      // mixed pseudo-random traffic
      for (int i = 0; i < 2000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         cyc(lf[0] | lf[5], lf[3], lf[15:10] == 6'd0);
      end

      // R11 asynchronous clear between edges
      cyc(1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b0);
      #2 aclr = 1'b1;
      #1;
      chk("R11 count cleared at once", int'(cnt0) + int'(cnt1) + int'(cnt2), 0);
      chk("R11 empty at once", int'(empty0 & empty1 & empty2), 1);
      chk("R11 normal rd_data cleared", int'(rd0) + int'(rd2), 0);
      @(negedge clk);
      aclr = 1'b0;
      q.delete(); exp0 = '0; exp2 = '0;
      chk_all();
      cyc(1'b1, 1'b0, 1'b0);
      cyc(1'b0, 1'b1, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule